// File: doc/BRIEF.md
# AES Vector Round Unit

This unit applies a single AES round step to a stream of 128-bit state groups. Each group holds four 32-bit elements. A command selects one of five round variants: encrypt middle or final, decrypt middle or final, or the bare key mix used before the first round. The same command also sets the element width code, the vector length and the start index.

After a command is accepted, the unit takes one state group per cycle on a valid/ready input. It returns the updated group one cycle later, tagged with its group number. The round key comes from one of two places. In the per-group form it arrives with each state group. In the shared form it is taken once, from the command's key input, which carries key group 0.

A command that fails the legality rules is refused with a one-cycle error pulse. When tail filling is requested, the unit finishes with all-ones groups up to the full register-group size. A one-cycle done pulse marks the end of the command.

Top module: `aesv_round_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_ready` is 1 and `in_ready`, `out_valid`, `done` and `illegal` are all 0.
- R2: Byte k of a group is bits [8k+7:8k]. Byte k sits in column k/4 and row k mod 4. Shift rows moves row r left by r columns, so output byte (col c, row r) comes from input (col (c+r) mod 4, row r). With `cmd_sel`=5'b00011 (final encrypt), the result is the key XORed with the shifted, byte-substituted state. An all-zero state and key therefore give 128'h6363…63.
- R3: With `cmd_sel`=5'b00010 (middle encrypt), the unit substitutes bytes, shifts rows, applies MixColumns to each column, then XORs the key.
- R4: With `cmd_sel`=5'b00001 (final decrypt), the unit applies inverse shift rows and the inverse S-box, then XORs the key.
- R5: With `cmd_sel`=5'b00000 (middle decrypt), the unit applies inverse shift rows, the inverse S-box and the key XOR, then InvMixColumns on each column.
- R6: With `cmd_sel`=5'b00111 in shared-key form (`cmd_funct6`=6'b101001), the result is the state XORed with the key. The same field in per-group form (6'b101000) is illegal.
- R7: With `cmd_funct6`=6'b101000, each group uses the `in_key` that arrives with it. With 6'b101001, every group uses `cmd_scalar_key` and `in_key` has no effect.
- R8: A command is illegal when any of these hold: `cmd_sew` is not 3'b010 (32-bit elements); `cmd_vl` or `cmd_vstart` is not a multiple of 4; `cmd_vl` exceeds 4·VLMAX_GROUPS; `cmd_funct6` is neither legal code; `cmd_sel` is none of the five codes. An illegal command gives `illegal`=1 in the cycle after acceptance, with no input taken, no output beat and no `done`.
- R9: The body groups run from `cmd_vstart`/4 to `cmd_vl`/4−1, in rising order. Each accepted input beat produces exactly one output beat in the next cycle, with `out_group` equal to that group's number. `in_ready` is high only while body groups remain.
- R10: If `cmd_vstart` ≥ `cmd_vl`, `done` rises in the cycle after acceptance. No input is taken, no output beat is produced, and no tail is filled.
- R11: With `cmd_tail_ones`=1, a non-empty body and `cmd_vl` < 4·VLMAX_GROUPS, the unit follows the body with groups `cmd_vl`/4 to VLMAX_GROUPS−1. These come one per cycle, with all-ones data and `out_tail`=1.
- R12: `done` is a one-cycle pulse that coincides with the last output beat. `cmd_ready` is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle; command taken when both high |
| cmd_funct6 | input | 6 | Key form: 101000 per-group, 101001 shared |
| cmd_sel | input | 5 | Round variant code |
| cmd_sew | input | 3 | Element width code, 3'b010 = 32 bits |
| cmd_vl | input | LEN_W | Vector length in elements |
| cmd_vstart | input | LEN_W | Start index in elements |
| cmd_tail_ones | input | 1 | Fill tail groups with all ones |
| cmd_scalar_key | input | 128 | Key group 0 for the shared form |
| in_valid | input | 1 | State group offered |
| in_ready | output | 1 | State group accepted when both high |
| in_state | input | 128 | State group |
| in_key | input | 128 | Round key for this group (per-group form) |
| out_valid | output | 1 | Output group valid |
| out_data | output | 128 | Updated state or tail fill |
| out_group | output | GRP_W | Group number of the output |
| out_tail | output | 1 | Output is a tail fill group |
| done | output | 1 | Command finished |
| illegal | output | 1 | Command refused |

## Verification
The bench builds the unit with VLMAX_GROUPS = 8, which makes the length fields 6 bits wide. That brings within reach the full 32-element length, which has no tail. It also reaches a 36-element length, which fits in the field and must be refused. Tails of every size from one group up to most of the register group can be exercised. Start indices in the middle of the group are covered, both with and without input gaps. A start index at or beyond the length gives an empty command.

// File: rtl/aesv_pkg.sv
package aesv_pkg;

  localparam int BLK_W = 128;
  localparam int NCOLS = 4;

  localparam logic [5:0] FN_VEC_VEC = 6'b101000;
  localparam logic [5:0] FN_VEC_SCL = 6'b101001;
  localparam logic [2:0] EW_CODE_32 = 3'b010;

  typedef enum logic [2:0] {
    RND_ENC_MID,
    RND_ENC_FIN,
    RND_DEC_MID,
    RND_DEC_FIN,
    RND_KEY_ONLY
  } rnd_op_e;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // a^254 is the field inverse (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rol8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ rol8(b, 1) ^ rol8(b, 2) ^ rol8(b, 3) ^ rol8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox_inv(input logic [7:0] y);
    return gf_inv(rol8(y, 1) ^ rol8(y, 3) ^ rol8(y, 6) ^ 8'h05);
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] c);
    logic [31:0] o;
    for (int r = 0; r < 4; r++) begin
      o[8*r +: 8] = gf_dbl(c[8*r +: 8])
                  ^ gf_dbl(c[8*((r+1)%4) +: 8]) ^ c[8*((r+1)%4) +: 8]
                  ^ c[8*((r+2)%4) +: 8] ^ c[8*((r+3)%4) +: 8];
    end
    return o;
  endfunction

  function automatic logic [31:0] inv_mix_col(input logic [31:0] c);
    logic [31:0] o;
    for (int r = 0; r < 4; r++) begin
      o[8*r +: 8] = gf_mul(c[8*r +: 8], 8'h0e)
                  ^ gf_mul(c[8*((r+1)%4) +: 8], 8'h0b)
                  ^ gf_mul(c[8*((r+2)%4) +: 8], 8'h0d)
                  ^ gf_mul(c[8*((r+3)%4) +: 8], 8'h09);
    end
    return o;
  endfunction

endpackage

// File: rtl/aesv_sbox_bank.sv
module aesv_sbox_bank #(
  parameter int NBYTES  = 16,
  parameter bit INVERSE = 1'b0
) (
  input  logic [8*NBYTES-1:0] din,
  output logic [8*NBYTES-1:0] dout
);
  import aesv_pkg::*;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    if (INVERSE) begin : g_inv
      assign dout[8*k +: 8] = sbox_inv(din[8*k +: 8]);
    end else begin : g_fwd
      assign dout[8*k +: 8] = sbox_fwd(din[8*k +: 8]);
    end
  end
endmodule

// File: rtl/aesv_round_dp.sv
module aesv_round_dp import aesv_pkg::*; (
  input  logic [BLK_W-1:0] st,
  input  logic [BLK_W-1:0] rk,
  input  rnd_op_e          op,
  output logic [BLK_W-1:0] res
);
  localparam int NB = BLK_W / 8;

  logic [BLK_W-1:0] sb_o, sr_o, mc_o;
  logic [BLK_W-1:0] isr_o, isb_o, dk_o, imc_o;

  aesv_sbox_bank #(.NBYTES(NB), .INVERSE(1'b0)) u_fwd (.din(st),    .dout(sb_o));
  aesv_sbox_bank #(.NBYTES(NB), .INVERSE(1'b1)) u_inv (.din(isr_o), .dout(isb_o));

  // row r rotates left by r columns (forward) or right by r (inverse)
  always_comb begin
    for (int c = 0; c < NCOLS; c++) begin
      for (int r = 0; r < 4; r++) begin
        sr_o[8*(4*c+r) +: 8]  = sb_o[8*(4*((c+r)%NCOLS)+r) +: 8];
        isr_o[8*(4*c+r) +: 8] = st[8*(4*((c+NCOLS-r)%NCOLS)+r) +: 8];
      end
    end
  end

  assign dk_o = isb_o ^ rk;

  always_comb begin
    for (int c = 0; c < NCOLS; c++) begin
      mc_o[32*c +: 32]  = mix_col(sr_o[32*c +: 32]);
      imc_o[32*c +: 32] = inv_mix_col(dk_o[32*c +: 32]);
    end
  end

  always_comb begin
    case (op)
      RND_ENC_FIN: res = sr_o ^ rk;
      RND_ENC_MID: res = mc_o ^ rk;
      RND_DEC_FIN: res = dk_o;
      RND_DEC_MID: res = imc_o;
      default:     res = st ^ rk;
    endcase
  end
endmodule

// File: rtl/aesv_ctrl.sv
module aesv_ctrl import aesv_pkg::*; #(
  parameter int VLMAX_GROUPS = 8,
  parameter int LEN_W        = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [5:0]       funct6,
  input  logic [4:0]       sel,
  input  logic [2:0]       sew,
  input  logic [LEN_W-1:0] vl,
  input  logic [LEN_W-1:0] vstart,
  input  logic             tail_ones,
  input  logic             in_valid,
  output logic             cmd_ready,
  output logic             in_ready,
  output logic             body_beat,
  output logic             tail_beat,
  output logic [LEN_W-3:0] grp,
  output rnd_op_e          op,
  output logic             scalar,
  output logic             done,
  output logic             illegal
);
  localparam int CNT_W = LEN_W - 2;
  localparam logic [CNT_W-1:0] GRP_CAP  = CNT_W'(VLMAX_GROUPS);
  localparam logic [CNT_W-1:0] LAST_GRP = CNT_W'(VLMAX_GROUPS - 1);
  localparam logic [LEN_W-1:0] VL_LIMIT = LEN_W'(4 * VLMAX_GROUPS);

  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_TAIL} ctl_st_e;

  ctl_st_e        st_q;
  logic [CNT_W-1:0] cur_q, end_q, nxt;
  rnd_op_e        op_q, dec_op;
  logic           scl_q, fill_q, is_scl, dec_ok, legal;

  always_comb begin
    is_scl = (funct6 == FN_VEC_SCL);
    dec_ok = is_scl || (funct6 == FN_VEC_VEC);
    dec_op = RND_KEY_ONLY;
    case (sel)
      5'b00000: dec_op = RND_DEC_MID;
      5'b00001: dec_op = RND_DEC_FIN;
      5'b00010: dec_op = RND_ENC_MID;
      5'b00011: dec_op = RND_ENC_FIN;
      5'b00111: begin
        dec_op = RND_KEY_ONLY;
        if (!is_scl) dec_ok = 1'b0;
      end
      default:  dec_ok = 1'b0;
    endcase
    legal = dec_ok && (sew == EW_CODE_32) && (vl[1:0] == 2'b00)
         && (vstart[1:0] == 2'b00) && (vl <= VL_LIMIT);
  end

  assign nxt = cur_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      end_q   <= '0;
      op_q    <= RND_KEY_ONLY;
      scl_q   <= 1'b0;
      fill_q  <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      case (st_q)
        ST_IDLE: if (cmd_valid) begin
          if (!legal) begin
            illegal <= 1'b1;
          end else begin
            op_q   <= dec_op;
            scl_q  <= is_scl;
            fill_q <= tail_ones;
            cur_q  <= vstart[LEN_W-1:2];
            end_q  <= vl[LEN_W-1:2];
            if (vstart >= vl) done <= 1'b1;
            else              st_q <= ST_BODY;
          end
        end
        ST_BODY: if (in_valid) begin
          cur_q <= nxt;
          if (nxt == end_q) begin
            if (fill_q && (end_q != GRP_CAP)) begin
              st_q <= ST_TAIL;
            end else begin
              st_q <= ST_IDLE;
              done <= 1'b1;
            end
          end
        end
        ST_TAIL: begin
          cur_q <= nxt;
          if (cur_q == LAST_GRP) begin
            st_q <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign in_ready  = (st_q == ST_BODY);
  assign body_beat = in_ready && in_valid;
  assign tail_beat = (st_q == ST_TAIL);
  assign grp       = cur_q;
  assign op        = op_q;
  assign scalar    = scl_q;
endmodule

// File: rtl/aesv_round_unit.sv
module aesv_round_unit import aesv_pkg::*; #(
  parameter  int VLMAX_GROUPS = 8,
  localparam int LEN_W        = $clog2(4 * VLMAX_GROUPS + 1),
  localparam int GRP_W        = $clog2(VLMAX_GROUPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [5:0]       cmd_funct6,
  input  logic [4:0]       cmd_sel,
  input  logic [2:0]       cmd_sew,
  input  logic [LEN_W-1:0] cmd_vl,
  input  logic [LEN_W-1:0] cmd_vstart,
  input  logic             cmd_tail_ones,
  input  logic [BLK_W-1:0] cmd_scalar_key,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_state,
  input  logic [BLK_W-1:0] in_key,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_data,
  output logic [GRP_W-1:0] out_group,
  output logic             out_tail,
  output logic             done,
  output logic             illegal
);
  logic             body_beat, tail_beat, scalar;
  logic [LEN_W-3:0] grp;
  rnd_op_e          op;
  logic [BLK_W-1:0] key_q, key_sel, rnd_res;

  aesv_ctrl #(.VLMAX_GROUPS(VLMAX_GROUPS), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .funct6(cmd_funct6),
    .sel(cmd_sel), .sew(cmd_sew), .vl(cmd_vl), .vstart(cmd_vstart),
    .tail_ones(cmd_tail_ones), .in_valid(in_valid), .cmd_ready(cmd_ready),
    .in_ready(in_ready), .body_beat(body_beat), .tail_beat(tail_beat),
    .grp(grp), .op(op), .scalar(scalar), .done(done), .illegal(illegal)
  );

  always_ff @(posedge clk) begin
    if (cmd_valid && cmd_ready) key_q <= cmd_scalar_key;
  end

  assign key_sel = scalar ? key_q : in_key;

  aesv_round_dp u_dp (.st(in_state), .rk(key_sel), .op(op), .res(rnd_res));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_tail  <= 1'b0;
      out_group <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= body_beat || tail_beat;
      out_tail  <= tail_beat;
      if (body_beat) begin
        out_data  <= rnd_res;
        out_group <= grp[GRP_W-1:0];
      end else if (tail_beat) begin
        out_data  <= '1;
        out_group <= grp[GRP_W-1:0];
      end
    end
  end
endmodule

// File: rtl/aesv_round_unit_chk.sv
module aesv_round_unit_chk #(
  parameter int GRP_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [127:0]     out_data,
  input logic [GRP_W-1:0] out_group,
  input logic             out_tail,
  input logic             done,
  input logic             illegal
);
  // R12
  done_vs_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && illegal));

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd_ready);

  // R8
  illegal_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(cmd_valid && cmd_ready));

  // R11
  tail_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    out_tail |-> (out_valid && (&out_data)));

  // R9
  beat_from_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_tail) |-> $past(in_valid && in_ready));

  // R9
  busy_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !cmd_ready);

  // R9
  group_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> (out_group == $past(out_group) + 1'b1));
endmodule

bind aesv_round_unit aesv_round_unit_chk #(.GRP_W(GRP_W)) i_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_group(out_group), .out_tail(out_tail),
  .done(done), .illegal(illegal)
);

// File: tb/test_aesv_round_unit.sv
module test_aesv_round_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VG    = 8;
  localparam int LEN_W = 6;
  localparam int GRP_W = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             cmd_valid, cmd_ready, cmd_tail_ones;
  logic [5:0]       cmd_funct6;
  logic [4:0]       cmd_sel;
  logic [2:0]       cmd_sew;
  logic [LEN_W-1:0] cmd_vl, cmd_vstart;
  logic [127:0]     cmd_scalar_key, in_state, in_key, out_data;
  logic             in_valid, in_ready, out_valid, out_tail, done, illegal;
  logic [GRP_W-1:0] out_group;

  always #(CLK_PERIOD/2) clk = ~clk;

  aesv_round_unit #(.VLMAX_GROUPS(VG)) i_aesv_round_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_funct6(cmd_funct6), .cmd_sel(cmd_sel), .cmd_sew(cmd_sew),
    .cmd_vl(cmd_vl), .cmd_vstart(cmd_vstart), .cmd_tail_ones(cmd_tail_ones),
    .cmd_scalar_key(cmd_scalar_key), .in_valid(in_valid), .in_ready(in_ready),
    .in_state(in_state), .in_key(in_key), .out_valid(out_valid),
    .out_data(out_data), .out_group(out_group), .out_tail(out_tail),
    .done(done), .illegal(illegal)
  );

  typedef struct {
    logic [127:0] d;
    int           g;
    bit           t;
  } beat_t;

  beat_t      expq[$];
  logic [7:0] fsb[256];
  logic [7:0] isb[256];
  int         n_chk = 0;
  int         n_bad = 0;
  string      cur_req = "R1";
  bit         finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] x;
    r = 0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1b) : {x[6:0], 1'b0};
    end
    return r;
  endfunction

  // sel: 0 dec mid, 1 dec fin, 2 enc mid, 3 enc fin, 7 key xor
  function automatic logic [127:0] model(input int sel, input logic [127:0] st,
                                         input logic [127:0] k);
    logic [7:0] s[16];
    logic [7:0] t[16];
    logic [7:0] u[16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = st[8*i +: 8];
    if (sel == 7) return st ^ k;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        if (sel >= 2) t[4*c+r] = fsb[s[4*((c+r)%4)+r]];
        else          t[4*c+r] = isb[s[4*((c+4-r)%4)+r]];
    if (sel < 2)
      for (int i = 0; i < 16; i++) t[i] = t[i] ^ k[8*i +: 8];
    for (int i = 0; i < 16; i++) u[i] = t[i];
    if (sel == 2 || sel == 0)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          if (sel == 2)
            u[4*c+r] = bmul(t[4*c+r], 2) ^ bmul(t[4*c+(r+1)%4], 3)
                     ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
          else
            u[4*c+r] = bmul(t[4*c+r], 14) ^ bmul(t[4*c+(r+1)%4], 11)
                     ^ bmul(t[4*c+(r+2)%4], 13) ^ bmul(t[4*c+(r+3)%4], 9);
    for (int i = 0; i < 16; i++) o[8*i +: 8] = u[i];
    if (sel >= 2) o = o ^ k;
    return o;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  always @(negedge clk) begin
    beat_t e;
    if (!rst && out_valid && !finished) begin
      if (expq.size() == 0) begin
        chk(1'b0, cur_req, "unexpected output beat", out_data, '0);
      end else begin
        e = expq.pop_front();
        chk(out_data === e.d && out_group === GRP_W'(e.g) && out_tail === e.t,
            cur_req, $sformatf("group %0d data (tail %0b exp %0b, grp %0d)",
            e.g, out_tail, e.t, out_group), out_data, e.d);
      end
    end
  end

  task automatic run_cmd(input string req, input logic [5:0] f6, input logic [4:0] sel,
                         input logic [2:0] sew, input int vl, input int vs,
                         input bit fill, input int gap, input bit zero_data);
    logic [127:0] skey, st, ik;
    beat_t        e;
    bit           scl, lgl, acc;
    int           waited;
    cur_req = req;
    scl = (f6 == 6'b101001);
    lgl = (f6 == 6'b101000 || scl) && (sel <= 3 || (sel == 7 && scl))
       && sew == 3'b010 && vl % 4 == 0 && vs % 4 == 0 && vl <= 4*VG;
    skey = zero_data ? '0 : rnd128();
    cmd_valid = 1; cmd_funct6 = f6; cmd_sel = sel; cmd_sew = sew;
    cmd_vl = LEN_W'(vl); cmd_vstart = LEN_W'(vs); cmd_tail_ones = fill;
    cmd_scalar_key = skey;
    chk(cmd_ready === 1'b1, "R12", "cmd_ready when idle", 128'(cmd_ready), 128'd1);
    @(negedge clk);
    cmd_valid = 0;
    cmd_scalar_key = rnd128();
    if (!lgl) begin
      chk(illegal === 1'b1 && done === 1'b0 && in_ready === 1'b0, "R8",
          "illegal pulse without done", {illegal, done, in_ready}, 128'b100);
    end else if (vs >= vl) begin
      chk(done === 1'b1 && in_ready === 1'b0, "R10", "empty command done",
          {done, in_ready}, 128'b10);
    end else begin
      for (int g = vs/4; g < vl/4; g++) begin
        st = zero_data ? '0 : rnd128();
        ik = zero_data ? '0 : rnd128();
        e.d = model(int'(sel), st, scl ? skey : ik);
        e.g = g; e.t = 0;
        expq.push_back(e);
        for (int z = 0; z < gap; z++) begin
          in_valid = 0; in_state = rnd128(); in_key = rnd128();
          @(negedge clk);
        end
        in_valid = 1; in_state = st; in_key = ik;
        acc = 0;
        while (!acc) begin
          acc = in_ready;
          @(negedge clk);
        end
      end
      in_valid = 0;
      if (fill)
        for (int g = vl/4; g < VG; g++) begin
          e.d = '1; e.g = g; e.t = 1;
          expq.push_back(e);
        end
      waited = 0;
      while (!done && waited < 4*VG + 8) begin
        @(negedge clk);
        waited++;
      end
      chk(done === 1'b1 && out_valid === 1'b1, "R12", "done with last beat",
          {done, out_valid}, 128'b11);
    end
    @(negedge clk);
    #1;
    chk(expq.size() == 0, req, "all expected beats seen", expq.size(), 0);
    chk(done === 1'b0 && illegal === 1'b0, "R12", "single-cycle pulses",
        {done, illegal}, 0);
    expq.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      fsb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    fsb[0] = 8'h63;
    for (int i = 0; i < 256; i++) isb[fsb[i]] = 8'(i);

    rst = 1; cmd_valid = 0; in_valid = 0; cmd_funct6 = 0; cmd_sel = 0; cmd_sew = 0;
    cmd_vl = 0; cmd_vstart = 0; cmd_tail_ones = 0; cmd_scalar_key = 0;
    in_state = 0; in_key = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cmd_ready === 1 && in_ready === 0 && out_valid === 0 && done === 0 && illegal === 0,
        "R1", "reset state", {cmd_ready, in_ready, out_valid, done, illegal}, 128'b10000);

    // R2 known answer: zero state, zero key -> all 0x63
    chk(model(3, '0, '0) === {16{8'h63}}, "R2", "model zero vector", model(3, '0, '0), {16{8'h63}});
    run_cmd("R2", 6'b101001, 5'b00011, 3'b010, 4, 0, 0, 0, 1);
    run_cmd("R2/R7", 6'b101000, 5'b00011, 3'b010, 16, 0, 0, 0, 0);
    run_cmd("R3", 6'b101000, 5'b00010, 3'b010, 32, 8, 0, 1, 0);
    run_cmd("R3/R7", 6'b101001, 5'b00010, 3'b010, 12, 4, 0, 0, 0);
    run_cmd("R4/R7", 6'b101001, 5'b00001, 3'b010, 12, 0, 0, 0, 0);
    run_cmd("R4", 6'b101000, 5'b00001, 3'b010, 8, 0, 0, 0, 0);
    run_cmd("R5", 6'b101000, 5'b00000, 3'b010, 20, 4, 0, 2, 0);
    run_cmd("R5/R7", 6'b101001, 5'b00000, 3'b010, 16, 8, 0, 0, 0);
    run_cmd("R6", 6'b101001, 5'b00111, 3'b010, 8, 0, 0, 0, 0);
    run_cmd("R6", 6'b101000, 5'b00111, 3'b010, 8, 0, 0, 0, 0);
    run_cmd("R8", 6'b101000, 5'b00011, 3'b011, 8, 0, 0, 0, 0);
    run_cmd("R8", 6'b101000, 5'b00011, 3'b010, 6, 0, 0, 0, 0);
    run_cmd("R8", 6'b101001, 5'b00010, 3'b010, 16, 2, 0, 0, 0);
    run_cmd("R8", 6'b101000, 5'b00100, 3'b010, 8, 0, 0, 0, 0);
    run_cmd("R8", 6'b100010, 5'b00011, 3'b010, 8, 0, 0, 0, 0);
    run_cmd("R8", 6'b101000, 5'b00011, 3'b010, 36, 0, 0, 0, 0);
    run_cmd("R10", 6'b101000, 5'b00011, 3'b010, 8, 8, 1, 0, 0);
    run_cmd("R10", 6'b101001, 5'b00000, 3'b010, 0, 0, 0, 0, 0);
    run_cmd("R11", 6'b101001, 5'b00010, 3'b010, 12, 0, 1, 0, 0);
    run_cmd("R11", 6'b101000, 5'b00001, 3'b010, 28, 20, 1, 1, 0);
    run_cmd("R11", 6'b101000, 5'b00011, 3'b010, 32, 24, 1, 0, 0);
    run_cmd("R9", 6'b101000, 5'b00010, 3'b010, 32, 0, 0, 3, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule